// File: doc/BRIEF.md
# Serial configuration shadow register

This block is a 32-bit memory-mapped register. It holds a local copy of configuration bits that live on a remote board. The remote board is reached over a three-wire serial link: a divided serial clock, a data-out line and a data-in line. A separate address input selects which remote location a transfer targets.

When the lock is open, a bus write stores the new value locally. It then sends a serial frame that carries the address and the new value to the remote side. A bus read always returns what the register held before that read. When the link is idle, the read also sends a short read-request frame. The remote side answers with 32 bits, and these replace the local copy in one step when the transfer ends. Software therefore reads twice to see fresh remote data.

A synchronous soft reset stops any transfer in flight but keeps the stored value. Only the asynchronous power-on reset restores the default.

Top module: `cfg_shadow_serial`

## Requirements
- R1: While `por_n` is low, the register reads 0x000F0000 (bits 19..16 set, all others clear) and `busy`, `ser_clk` and `ser_out` are low.
- R2: A bus write with `wr_lock` low and `soft_rst` low stores `bus_wdata`, and `bus_rdata` shows it from the next cycle on.
- R3: A write accepted while idle sends a 42-bit frame on `ser_out`, MSB first:
  - a start bit of 1,
  - the 8 bits of `rmt_addr`,
  - a direction bit of 0,
  - the 32 written data bits.

  Each bit lasts 4 clock cycles. `ser_clk` is low for the first two cycles of each bit period and high for the last two.
- R4: A bus read returns the contents held before it. When the link is idle and `bus_wr` is low, the read sends a frame of the same 42-bit length: a start bit of 1, the 8 bits of `rmt_addr`, a direction bit of 1, then 32 zero bits.
  - During the last 32 bit periods, `ser_in` is sampled at the end of the second cycle of each period, MSB first.
  - The 32 sampled bits replace the register contents in one step on the final cycle of the transfer, and not before.
- R5: `busy` rises in the cycle after a transfer starts and stays high for exactly 168 cycles. While `busy` is low, `ser_clk` and `ser_out` are low.
- R6: A bus write with `wr_lock` high leaves the contents unchanged and starts no transfer.
- R7: A write or read that arrives while `busy` is high starts no new transfer, and the transfer in flight runs to its normal end.
  - An unlocked write in that window still updates the contents.
  - If that write lands on the final cycle of a read, the write wins over the fetched value.
- R8: `soft_rst` high ends any transfer at the next edge (`busy`, `ser_clk` and `ser_out` go low) and keeps the contents unchanged. An in-flight read commits nothing, and a bus write in the same cycle is ignored.
- R9: The reserved bits 24 and 3 are stored and read back like any other bit.
- R10: When `bus_wr` and `bus_rd` are both high in one cycle, only the write is acted on. The frame sent is a write frame, and no fetched value is committed afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Asynchronous power-on reset, active low; restores the default value |
| soft_rst | input | 1 | Synchronous soft reset; aborts the transfer, keeps the contents |
| bus_wr | input | 1 | Single-cycle write strobe for this register |
| bus_rd | input | 1 | Single-cycle read strobe for this register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Current register contents |
| rmt_addr | input | 8 | Remote location, taken from the companion address register |
| wr_lock | input | 1 | High blocks bus writes |
| ser_clk | output | 1 | Serial bit clock, system clock divided by 4 |
| ser_out | output | 1 | Serial frame data toward the remote board |
| ser_in | input | 1 | Serial data returned by the remote board |
| busy | output | 1 | High while a serial transfer is in progress |

## Verification
The bench targets the following corner cases. Each is paired with the fault it would expose:
- **Double read.** The first read must return the old value and only the second the fetched one. A design that commits early, or bit by bit, would show partial or fresh data on the first read.
- **Bus activity during a transfer.** Writes and reads arrive while `busy` is high. A design that restarts the frame would lengthen `busy`. A design that drops the write would lose the stored value.
- **Soft reset mid-read.** A design that commits anyway, or wipes the contents, would change `bus_rdata`.
- **Locked writes and simultaneous strobes.** These are checked at `bus_rdata` and at the direction bit of the frame. A wrong priority sends a read request or commits a fetched value over the write.

// File: rtl/cfg_shadow_pkg.sv
package cfg_shadow_pkg;

    // Direction carried in the frame; encoding is the bit sent on the wire.
    typedef enum logic {
        XFER_WRITE = 1'b0,
        XFER_READ  = 1'b1
    } xfer_kind_e;

endpackage

// File: rtl/ser_bit_timer.sv
module ser_bit_timer #(
    parameter int CLK_DIV  = 4,
    parameter int NUM_BITS = 42
) (
    input  logic                        clk,
    input  logic                        por_n,
    input  logic                        abort,
    input  logic                        start,
    output logic                        active_o,
    output logic                        ser_clk_o,
    output logic                        bit_end_o,
    output logic                        sample_o,
    output logic                        last_o,
    output logic [$clog2(NUM_BITS)-1:0] bit_idx_o
);
    localparam int PH_W      = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
    localparam int BI_W      = $clog2(NUM_BITS);
    localparam int SAMPLE_PH = CLK_DIV / 2 - 1;
    localparam int HIGH_PH   = CLK_DIV / 2;

    typedef struct packed {
        logic            active;
        logic [PH_W-1:0] ph;
        logic [BI_W-1:0] idx;
    } timer_t;

    timer_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (abort) begin
            tmr_d.active = 1'b0;
            tmr_d.ph     = '0;
            tmr_d.idx    = '0;
        end else if (tmr_q.active) begin
            if (tmr_q.ph == PH_W'(CLK_DIV - 1)) begin
                tmr_d.ph = '0;
                if (tmr_q.idx == BI_W'(NUM_BITS - 1)) begin
                    tmr_d.active = 1'b0;
                    tmr_d.idx    = '0;
                end else begin
                    tmr_d.idx = tmr_q.idx + 1'b1;
                end
            end else begin
                tmr_d.ph = tmr_q.ph + 1'b1;
            end
        end else if (start) begin
            tmr_d.active = 1'b1;
            tmr_d.ph     = '0;
            tmr_d.idx    = '0;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign active_o  = tmr_q.active;
    assign ser_clk_o = tmr_q.active && (tmr_q.ph >= PH_W'(HIGH_PH));
    assign bit_end_o = tmr_q.active && (tmr_q.ph == PH_W'(CLK_DIV - 1));
    assign sample_o  = tmr_q.active && (tmr_q.ph == PH_W'(SAMPLE_PH));
    assign last_o    = bit_end_o && (tmr_q.idx == BI_W'(NUM_BITS - 1));
    assign bit_idx_o = tmr_q.idx;

endmodule

// File: rtl/cfg_frame_shifter.sv
module cfg_frame_shifter
    import cfg_shadow_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              load,
    input  xfer_kind_e        kind,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              shift,
    input  logic              capture,
    input  logic              ser_in,
    output logic              tx_bit,
    output logic [DATA_W-1:0] rx_word
);
    localparam int HDR_BITS   = ADDR_W + 2;
    localparam int FRAME_BITS = HDR_BITS + DATA_W;

    typedef struct packed {
        logic [FRAME_BITS-1:0] tx;
        logic [DATA_W-1:0]     rx;
    } shift_t;

    shift_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (load) begin
            // start flag, address, direction, payload (zeros for a fetch)
            sh_d.tx = {1'b1, addr, logic'(kind),
                       (kind == XFER_READ) ? {DATA_W{1'b0}} : wdata};
            sh_d.rx = '0;
        end else begin
            if (shift) begin
                sh_d.tx = {sh_q.tx[FRAME_BITS-2:0], 1'b0};
            end
            if (capture) begin
                sh_d.rx = {sh_q.rx[DATA_W-2:0], ser_in};
            end
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign tx_bit  = sh_q.tx[FRAME_BITS-1];
    assign rx_word = sh_q.rx;

endmodule

// File: rtl/cfg_shadow_store.sv
module cfg_shadow_store #(
    parameter int                DATA_W    = 32,
    parameter logic [DATA_W-1:0] RESET_VAL = 32'h000F_0000
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              commit_en,
    input  logic [DATA_W-1:0] commit_data,
    output logic [DATA_W-1:0] value
);
    typedef struct packed {
        logic [DATA_W-1:0] word;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // a bus write lands after the fetched word, so it wins a tie
        if (commit_en) begin
            st_d.word = commit_data;
        end
        if (wr_en) begin
            st_d.word = wr_data;
        end
    end

    // only the power-on reset touches the contents
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q.word <= RESET_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign value = st_q.word;

endmodule

// File: rtl/cfg_shadow_serial.sv
module cfg_shadow_serial
    import cfg_shadow_pkg::*;
#(
    parameter int                DATA_W    = 32,
    parameter int                ADDR_W    = 8,
    parameter int                CLK_DIV   = 4,
    parameter logic [DATA_W-1:0] RESET_VAL = 32'h000F_0000
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              soft_rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [ADDR_W-1:0] rmt_addr,
    input  logic              wr_lock,
    output logic              ser_clk,
    output logic              ser_out,
    input  logic              ser_in,
    output logic              busy
);
    localparam int HDR_BITS   = ADDR_W + 2;
    localparam int FRAME_BITS = HDR_BITS + DATA_W;
    localparam int BI_W       = $clog2(FRAME_BITS);

    typedef struct packed {
        xfer_kind_e kind;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic            active;
    logic            bit_end;
    logic            sample;
    logic            last;
    logic [BI_W-1:0] bit_idx;
    logic            tx_bit;
    logic [DATA_W-1:0] rx_word;
    logic [DATA_W-1:0] shadow;

    logic wr_go, start_wr, start_rd, xfer_start, commit, capture;

    always_comb begin
        wr_go      = bus_wr && !wr_lock && !soft_rst;
        start_wr   = wr_go && !active;
        start_rd   = bus_rd && !bus_wr && !soft_rst && !active;
        xfer_start = start_wr || start_rd;
        commit     = last && (ctl_q.kind == XFER_READ) && !soft_rst;
        capture    = sample && (ctl_q.kind == XFER_READ)
                     && (bit_idx >= BI_W'(HDR_BITS));
        ctl_d = ctl_q;
        if (start_rd) begin
            ctl_d.kind = XFER_READ;
        end else if (start_wr) begin
            ctl_d.kind = XFER_WRITE;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            ctl_q.kind <= XFER_WRITE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    ser_bit_timer #(
        .CLK_DIV  (CLK_DIV),
        .NUM_BITS (FRAME_BITS)
    ) u_timer (
        .clk       (clk),
        .por_n     (por_n),
        .abort     (soft_rst),
        .start     (xfer_start),
        .active_o  (active),
        .ser_clk_o (ser_clk),
        .bit_end_o (bit_end),
        .sample_o  (sample),
        .last_o    (last),
        .bit_idx_o (bit_idx)
    );

    cfg_frame_shifter #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_shift (
        .clk     (clk),
        .por_n   (por_n),
        .load    (xfer_start),
        .kind    (start_rd ? XFER_READ : XFER_WRITE),
        .addr    (rmt_addr),
        .wdata   (bus_wdata),
        .shift   (bit_end),
        .capture (capture),
        .ser_in  (ser_in),
        .tx_bit  (tx_bit),
        .rx_word (rx_word)
    );

    cfg_shadow_store #(
        .DATA_W    (DATA_W),
        .RESET_VAL (RESET_VAL)
    ) u_store (
        .clk         (clk),
        .por_n       (por_n),
        .wr_en       (wr_go),
        .wr_data     (bus_wdata),
        .commit_en   (commit),
        .commit_data (rx_word),
        .value       (shadow)
    );

    assign bus_rdata = shadow;
    assign ser_out   = active && tx_bit;
    assign busy      = active;

endmodule

// File: rtl/cfg_shadow_serial_chk.sv
module cfg_shadow_serial_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              por_n,
    input logic              soft_rst,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              wr_lock,
    input logic              ser_clk,
    input logic              ser_out,
    input logic              busy
);
    // R2: unlocked write is visible on the next cycle, even mid-transfer
    a_r2_write_loads: assert property (@(posedge clk) disable iff (!por_n)
        (bus_wr && !wr_lock && !soft_rst) |=> (bus_rdata == $past(bus_wdata)));

    // R4: idle read raises busy, starts with the start bit, keeps contents
    a_r4_read_starts: assert property (@(posedge clk) disable iff (!por_n)
        (bus_rd && !bus_wr && !busy && !soft_rst) |=> (busy && ser_out && $stable(bus_rdata)));

    // R5: serial lines rest low whenever no transfer runs
    a_r5_idle_lines: assert property (@(posedge clk) disable iff (!por_n)
        !busy |-> (!ser_clk && !ser_out));

    // R6: locked write alone changes nothing and sends nothing
    a_r6_locked_write: assert property (@(posedge clk) disable iff (!por_n)
        (bus_wr && wr_lock && !bus_rd && !busy && !soft_rst) |=> (!busy && $stable(bus_rdata)));

    // R8: soft reset ends the transfer and keeps the contents
    a_r8_soft_abort: assert property (@(posedge clk) disable iff (!por_n)
        soft_rst |=> (!busy && $stable(bus_rdata)));

endmodule

bind cfg_shadow_serial cfg_shadow_serial_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .por_n     (por_n),
    .soft_rst  (soft_rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .wr_lock   (wr_lock),
    .ser_clk   (ser_clk),
    .ser_out   (ser_out),
    .busy      (busy)
);

// File: tb/cfg_shadow_serial_test.sv
module cfg_shadow_serial_test;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 8;
    localparam int CLK_DIV  = 4;
    localparam int HDR      = ADDR_W + 2;
    localparam int FBITS    = HDR + DATA_W;
    localparam int XFER_CYC = FBITS * CLK_DIV;
    localparam logic [31:0] DEF = 32'h000F_0000;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        por_n, soft_rst, bus_wr, bus_rd, wr_lock, ser_in;
    logic [31:0] bus_wdata, bus_rdata;
    logic [7:0]  rmt_addr;
    logic        ser_clk, ser_out, busy;

    cfg_shadow_serial uut (
        .clk(clk), .por_n(por_n), .soft_rst(soft_rst), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rmt_addr(rmt_addr), .wr_lock(wr_lock), .ser_clk(ser_clk),
        .ser_out(ser_out), .ser_in(ser_in), .busy(busy)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit done     = 1'b0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    endtask

    // Behavioural reference: elapsed-cycle count plus a whole-frame vector.
    logic [31:0]      m_shadow, m_cap, rem_val;
    logic [FBITS-1:0] m_frame;
    bit               m_busy, m_rd;
    int               m_t;

    always @(posedge clk or negedge por_n) begin : model
        bit was_busy, wr_ok, rd_ok;
        if (!por_n) begin
            m_shadow = DEF; m_busy = 0; m_rd = 0; m_t = 0; m_cap = 0; m_frame = '0;
        end else begin
            was_busy = m_busy;
            wr_ok = bus_wr && !wr_lock && !soft_rst;
            rd_ok = bus_rd && !bus_wr && !soft_rst && !m_busy;
            if (m_busy && m_rd && (m_t % CLK_DIV) == CLK_DIV/2 - 1 && (m_t / CLK_DIV) >= HDR)
                m_cap = {m_cap[30:0], ser_in};
            if (soft_rst) m_busy = 0;
            else if (m_busy && m_t == XFER_CYC - 1) begin
                m_busy = 0;
                if (m_rd) m_shadow = m_cap;
            end else if (m_busy) m_t++;
            if (wr_ok) m_shadow = bus_wdata;
            if (wr_ok && !was_busy) begin
                m_busy = 1; m_t = 0; m_rd = 0; m_frame = {1'b1, rmt_addr, 1'b0, bus_wdata};
            end else if (rd_ok) begin
                m_busy = 1; m_t = 0; m_rd = 1; m_cap = 0; m_frame = {1'b1, rmt_addr, 1'b1, 32'h0};
            end
        end
    end

    // Per-cycle comparison and remote-side answer, away from the active edge.
    always @(negedge clk) begin
        if (por_n && !done) begin
            check("R5 busy", {31'b0, busy}, {31'b0, m_busy});
            check("R3 ser_clk", {31'b0, ser_clk}, {31'b0, m_busy && (m_t % CLK_DIV) >= CLK_DIV/2});
            check("R3 ser_out", {31'b0, ser_out}, {31'b0, m_busy && m_frame[FBITS - 1 - m_t / CLK_DIV]});
            check("R4 rdata vs model", bus_rdata, m_shadow);
        end
        ser_in = 1'b0;
        if (m_busy && m_rd && (m_t / CLK_DIV) >= HDR)
            ser_in = rem_val[DATA_W - 1 - (m_t / CLK_DIV - HDR)];
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        rmt_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] got);
        rmt_addr = a; bus_rd = 1'b1; got = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy) begin n++; @(negedge clk); end
    endtask

    initial begin
        logic [31:0] got;
        int n;
        por_n = 0; soft_rst = 0; bus_wr = 0; bus_rd = 0; wr_lock = 0;
        bus_wdata = 0; rmt_addr = 0; rem_val = 0; ser_in = 0;
        repeat (3) @(negedge clk);
        check("R1 default in reset", bus_rdata, DEF);
        check("R1 busy in reset", {31'b0, busy}, 0);
        por_n = 1;
        @(negedge clk);
        check("R1 default after reset", bus_rdata, DEF);

        bus_write(8'h5A, 32'hA5C3_0F81);
        check("R2 readback", bus_rdata, 32'hA5C3_0F81);
        wait_idle(n);
        check("R5 write busy length", n, XFER_CYC);

        rem_val = 32'h1234_5678;
        bus_read(8'h11, got);
        check("R4 first read stale", got, 32'hA5C3_0F81);
        wait_idle(n);
        check("R5 read busy length", n, XFER_CYC);
        bus_read(8'h11, got);
        check("R4 second read fresh", got, 32'h1234_5678);
        wait_idle(n);

        wr_lock = 1;
        bus_write(8'h22, 32'hFFFF_FFFF);
        check("R6 locked contents", bus_rdata, 32'h1234_5678);
        check("R6 no transfer", {31'b0, busy}, 0);
        wr_lock = 0;

        bus_write(8'h01, 32'h0100_0008);
        check("R9 reserved bits stored", bus_rdata, 32'h0100_0008);
        wait_idle(n);

        bus_write(8'h33, 32'hCAFE_0001);
        repeat (20) @(negedge clk);
        bus_write(8'h44, 32'h0BAD_F00D);
        check("R7 busy write stored", bus_rdata, 32'h0BAD_F00D);
        bus_read(8'h44, got);
        wait_idle(n);
        check("R7 no restart", n, XFER_CYC - 22);
        check("R7 contents after", bus_rdata, 32'h0BAD_F00D);

        rem_val = 32'h7777_1111;
        bus_read(8'h55, got);
        repeat (100) @(negedge clk);
        soft_rst = 1; bus_wr = 1; bus_wdata = 32'hDEAD_BEEF;
        @(negedge clk);
        soft_rst = 0; bus_wr = 0;
        check("R8 busy cleared", {31'b0, busy}, 0);
        check("R8 ser_clk low", {31'b0, ser_clk}, 0);
        check("R8 contents kept", bus_rdata, 32'h0BAD_F00D);
        repeat (200) @(negedge clk);
        check("R8 no late commit", bus_rdata, 32'h0BAD_F00D);

        rem_val = 32'h9999_AAAA;
        rmt_addr = 8'h66; bus_wdata = 32'h600D_0002; bus_wr = 1; bus_rd = 1;
        @(negedge clk);
        bus_wr = 0; bus_rd = 0;
        check("R10 write wins", bus_rdata, 32'h600D_0002);
        wait_idle(n);
        check("R10 nothing committed", bus_rdata, 32'h600D_0002);

        bus_write(8'h77, 32'h1357_2468);
        repeat (10) @(negedge clk);
        por_n = 0;
        @(negedge clk);
        check("R1 power-on default", bus_rdata, DEF);
        check("R1 power-on busy", {31'b0, busy}, 0);
        por_n = 1;
        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule